// File: doc/BRIEF.md
# Sequential Floating-Point Adder

This block adds two 32-bit floating-point words under a four-phase request/done handshake. A word holds a sign in bit 31, an 8-bit exponent field in bits 30:23 with a bias of 128, and a 23-bit fraction in bits 22:0. The fraction has an implied leading one, so a word with exponent field e and fraction f stands for (-1)^sign x 1.f x 2^(e-128). Any word whose exponent field is zero counts as zero.

A controlling process places both operands on the inputs and raises the request. The block captures the operands and passes through fixed phases: align, add and normalize. It then raises done and holds the result until the request falls. A subtraction is requested by inverting the sign bit of one operand before raising the request.

Alignment uses one variable right shift of the smaller operand's significand. Renormalization uses one shift set by a leading-zero count. Every operation therefore takes the same number of clocks, whatever the operands' magnitudes. There is no rounding. Bits shifted out are dropped. An exponent above the field's range saturates and one below it flushes to zero.

Top module: `fpadd_seq`

## Requirements
- R1: Two operands of the same sign add their magnitudes, and the result carries that sign (for example 0x40000000 + 0x40400000 = 0x40A00000, that is 1.0 + 1.5 = 2.5).
- R2: In idle the block waits for req high. The rising edge that samples req high is edge 1, and done rises after edge 4. While req stays high, done stays high and sum_word holds. The first rising edge that samples req low clears done.
- R3: Operands are sampled only on the edge that accepts the request. Changing opnd_a or opnd_b later in the operation does not change the result.
- R4: The smaller-magnitude significand is shifted right by the exponent difference in one step, and bits shifted out are dropped. A difference of 24 or more leaves the larger operand unchanged.
- R5: With opposite signs, the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger-magnitude operand.
- R6: Operands that cancel exactly give 0x00000000.
- R7: A carry out of the significand sum shifts the significand right by one and raises the exponent by one. The dropped bit is truncated.
- R8: A difference with leading zeros is shifted left until the hidden bit is set, and the exponent is reduced by the same amount.
- R9: If the result exponent would exceed 255, the result is the sign followed by 31 ones.
- R10: If the result exponent would fall to 0 or below, the result is 0x00000000.
- R11: If opnd_a has exponent field 0, the result is opnd_b unchanged. Otherwise, if opnd_b has exponent field 0, the result is opnd_a unchanged.
- R12: While reset is asserted and after it is released, done is 0 and sum_word is 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| req | input | 1 | Operation request, held high until done is seen |
| opnd_a | input | 32 | First operand word |
| opnd_b | input | 32 | Second operand word |
| done | output | 1 | Result valid, held until req falls |
| sum_word | output | 32 | Result word |

## Verification
A result is due after the fourth rising edge, counted from the edge that first samples req high. The bench drives every input on the falling edge and counts four falling edges after raising req before it reads done and sum_word. A directed test also samples done at the three falling edges before that, to confirm it is still low. It then holds req for further cycles to check that the output is held, and drops req to check that done clears one edge later. Operand changes made after the accepting edge are checked against the result that is due on the same fourth cycle.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ALIGN = 3'd1,
    S_ADD   = 3'd2,
    S_NORM  = 3'd3,
    S_DONE  = 3'd4
  } fpadd_state_e;
endpackage

// File: rtl/fpadd_align.sv
module fpadd_align #(
  parameter int EXP_W  = fpadd_pkg::EXP_W,
  parameter int FRAC_W = fpadd_pkg::FRAC_W,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1
) (
  input  logic [WORD_W-1:0] word_a,
  input  logic [WORD_W-1:0] word_b,
  output logic [SIG_W-1:0]  big_sig,
  output logic [SIG_W-1:0]  small_sig,
  output logic [EXP_W-1:0]  big_exp,
  output logic              big_sign,
  output logic              eff_sub,
  output logic              pass,
  output logic [WORD_W-1:0] pass_word
);
  localparam logic [EXP_W-1:0] SH_LIM = EXP_W'(SIG_W);

  logic a_zero, b_zero, a_big;
  logic [WORD_W-1:0] w_big, w_small;
  logic [EXP_W-1:0]  diff;
  logic [SIG_W-1:0]  s_raw;

  always_comb begin
    a_zero    = (word_a[WORD_W-2 -: EXP_W] == '0);
    b_zero    = (word_b[WORD_W-2 -: EXP_W] == '0);
    pass      = a_zero || b_zero;
    pass_word = a_zero ? word_b : word_a;
    a_big     = (word_a[WORD_W-2:0] >= word_b[WORD_W-2:0]);
    w_big     = a_big ? word_a : word_b;
    w_small   = a_big ? word_b : word_a;
    big_exp   = w_big[WORD_W-2 -: EXP_W];
    big_sign  = w_big[WORD_W-1];
    eff_sub   = word_a[WORD_W-1] ^ word_b[WORD_W-1];
    big_sig   = {1'b1, w_big[FRAC_W-1:0]};
    s_raw     = {1'b1, w_small[FRAC_W-1:0]};
    diff      = big_exp - w_small[WORD_W-2 -: EXP_W];
    if (diff >= SH_LIM) small_sig = '0;
    else                small_sig = s_raw >> diff;
  end
endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm #(
  parameter int EXP_W  = fpadd_pkg::EXP_W,
  parameter int FRAC_W = fpadd_pkg::FRAC_W,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int SUM_W  = SIG_W + 1,
  localparam int LZ_W   = $clog2(SIG_W + 1),
  localparam int EXT_W  = EXP_W + 2
) (
  input  logic [SUM_W-1:0]  sum,
  input  logic [EXP_W-1:0]  exp_in,
  input  logic              sign_in,
  output logic [WORD_W-1:0] word_out
);
  localparam logic signed [EXT_W-1:0] E_TOP = EXT_W'((2 ** EXP_W) - 1);
  localparam logic signed [EXT_W-1:0] E_ONE = EXT_W'(1);

  logic [LZ_W-1:0]         lz;
  logic [SIG_W-1:0]        mant;
  logic signed [EXT_W-1:0] e_base, e_new;

  // leading-zero count over the lower SIG_W bits; highest set bit wins
  always_comb begin
    lz = LZ_W'(SIG_W);
    for (int i = 0; i < SIG_W; i++) begin
      if (sum[i]) lz = LZ_W'(SIG_W - 1 - i);
    end
  end

  always_comb begin
    e_base = signed'({2'b00, exp_in});
    if (sum[SUM_W-1]) begin
      mant  = sum[SUM_W-1:1];
      e_new = e_base + E_ONE;
    end else begin
      mant  = sum[SIG_W-1:0] << lz;
      e_new = e_base - signed'({{(EXT_W-LZ_W){1'b0}}, lz});
    end
    if (sum == '0)          word_out = '0;
    else if (e_new > E_TOP) word_out = {sign_in, {(WORD_W-1){1'b1}}};
    else if (e_new < E_ONE) word_out = '0;
    else                    word_out = {sign_in, e_new[EXP_W-1:0], mant[FRAC_W-1:0]};
  end
endmodule

// File: rtl/fpadd_seq.sv
module fpadd_seq #(
  parameter int EXP_W  = fpadd_pkg::EXP_W,
  parameter int FRAC_W = fpadd_pkg::FRAC_W,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int SIG_W  = FRAC_W + 1,
  localparam int SUM_W  = SIG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [WORD_W-1:0] opnd_a,
  input  logic [WORD_W-1:0] opnd_b,
  output logic              done,
  output logic [WORD_W-1:0] sum_word
);
  import fpadd_pkg::*;

  fpadd_state_e state_q, state_d;

  logic [WORD_W-1:0] a_q, b_q;
  logic [SIG_W-1:0]  big_sig_d, small_sig_d, big_sig_q, small_sig_q;
  logic [EXP_W-1:0]  exp_d, exp_q, exp2_q;
  logic              sign_d, sign_q, sign2_q;
  logic              sub_d, sub_q;
  logic              pass_d, pass_q, pass2_q;
  logic [WORD_W-1:0] pword_d, pword_q, pword2_q;
  logic [SUM_W-1:0]  sum_d, sum_q;
  logic [WORD_W-1:0] norm_word, res_d, res_q;

  logic cap_en, align_en, add_en, norm_en;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (req) state_d = S_ALIGN;
      S_ALIGN: state_d = S_ADD;
      S_ADD:   state_d = S_NORM;
      S_NORM:  state_d = S_DONE;
      S_DONE:  if (!req) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign cap_en   = (state_q == S_IDLE) && req;
  assign align_en = (state_q == S_ALIGN);
  assign add_en   = (state_q == S_ADD);
  assign norm_en  = (state_q == S_NORM);

  fpadd_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .word_a    (a_q),
    .word_b    (b_q),
    .big_sig   (big_sig_d),
    .small_sig (small_sig_d),
    .big_exp   (exp_d),
    .big_sign  (sign_d),
    .eff_sub   (sub_d),
    .pass      (pass_d),
    .pass_word (pword_d)
  );

  always_comb begin
    if (sub_q) sum_d = {1'b0, big_sig_q} - {1'b0, small_sig_q};
    else       sum_d = {1'b0, big_sig_q} + {1'b0, small_sig_q};
  end

  fpadd_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .sum      (sum_q),
    .exp_in   (exp2_q),
    .sign_in  (sign2_q),
    .word_out (norm_word)
  );

  assign res_d = pass2_q ? pword2_q : norm_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0;
    end else if (cap_en) begin
      a_q <= opnd_a; b_q <= opnd_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      big_sig_q <= '0; small_sig_q <= '0; exp_q <= '0;
      sign_q <= 1'b0; sub_q <= 1'b0; pass_q <= 1'b0; pword_q <= '0;
    end else if (align_en) begin
      big_sig_q <= big_sig_d; small_sig_q <= small_sig_d; exp_q <= exp_d;
      sign_q <= sign_d; sub_q <= sub_d; pass_q <= pass_d; pword_q <= pword_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0; exp2_q <= '0; sign2_q <= 1'b0; pass2_q <= 1'b0; pword2_q <= '0;
    end else if (add_en) begin
      sum_q <= sum_d; exp2_q <= exp_q; sign2_q <= sign_q;
      pass2_q <= pass_q; pword2_q <= pword_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       res_q <= '0;
    else if (norm_en) res_q <= res_d;
  end

  assign done     = (state_q == S_DONE);
  assign sum_word = res_q;
endmodule

// File: rtl/fpadd_seq_chk.sv
module fpadd_seq_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              done,
  input logic [WORD_W-1:0] sum_word
);
  // R2
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && req) |=> done);

  // R2
  done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !req) |=> !done);

  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && req) |=> $stable(sum_word));

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(req, 4) && !$past(done, 4)));

  // R12
  reset_out_chk: assert property (@(posedge clk)
    !rst_n |-> (!done && (sum_word == '0)));
endmodule

bind fpadd_seq fpadd_seq_chk #(.WORD_W(WORD_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req),
  .done     (done),
  .sum_word (sum_word)
);

// File: tb/fpadd_seq_tb.sv
module fpadd_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [31:0] opnd_a, opnd_b;
  logic        done;
  logic [31:0] sum_word;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  fpadd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .req(req),
    .opnd_a(opnd_a), .opnd_b(opnd_b),
    .done(done), .sum_word(sum_word)
  );

  // {a, b, expected, requirement number}
  localparam int NV = 20;
  localparam logic [103:0] VEC [NV] = '{
    {32'h40000000, 32'h40000000, 32'h40800000, 8'd1},  // R1 1+1
    {32'h40000000, 32'h40400000, 32'h40A00000, 8'd1},  // R1 1+1.5
    {32'h40400000, 32'h40000000, 32'h40A00000, 8'd1},  // R1 swapped
    {32'h40000000, 32'h34800000, 32'h40000001, 8'd4},  // R4 diff 23
    {32'h40000000, 32'h34000000, 32'h40000000, 8'd4},  // R4 diff 24
    {32'h31000000, 32'h40000000, 32'h40000000, 8'd4},  // R4 diff 30
    {32'h40800000, 32'hC0400000, 32'h3F800000, 8'd5},  // R5 2-1.5
    {32'hC0400000, 32'h40000000, 32'hBF800000, 8'd5},  // R5 -1.5+1
    {32'h40000000, 32'hC1000000, 32'hC0C00000, 8'd5},  // R5 1-4
    {32'h40000000, 32'hC0000000, 32'h00000000, 8'd6},  // R6 1-1
    {32'hC0A00000, 32'h40A00000, 32'h00000000, 8'd6},  // R6
    {32'h40000001, 32'h40000000, 32'h40800000, 8'd7},  // R7 truncated carry
    {32'h40400000, 32'h40400000, 32'h40C00000, 8'd7},  // R7 1.5+1.5
    {32'h40600000, 32'hC0400000, 32'h3F000000, 8'd8},  // R8 1.75-1.5
    {32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF, 8'd9},  // R9
    {32'hFF800000, 32'hFF800000, 32'hFFFFFFFF, 8'd9},  // R9 negative
    {32'h00800001, 32'h80800000, 32'h00000000, 8'd10}, // R10
    {32'h00C00000, 32'h80800000, 32'h00000000, 8'd10}, // R10
    {32'h00000000, 32'h40400000, 32'h40400000, 8'd11}, // R11 a zero
    {32'hC0400000, 32'h00123456, 32'hC0400000, 8'd11}  // R11 b zero
  };

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(input bit ok, input int rid, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d: actual %h expected %h", rid, act, expv);
    end
  endtask

  task automatic do_op(input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] expv, input int rid);
    @(negedge clk);
    opnd_a = a; opnd_b = b; req = 1'b1;
    repeat (4) @(negedge clk);
    chk(done === 1'b1, 2, {31'd0, done}, 32'd1);
    chk(sum_word === expv, rid, sum_word, expv);
    req = 1'b0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; opnd_a = '0; opnd_b = '0;
    repeat (2) @(negedge clk);
    // R12 during reset
    chk(done === 1'b0 && sum_word === 32'h0, 12, sum_word, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 after release
    chk(done === 1'b0 && sum_word === 32'h0, 12, sum_word, 32'h0);

    for (int i = 0; i < NV; i++)
      do_op(VEC[i][103:72], VEC[i][71:40], VEC[i][39:8], int'(VEC[i][7:0]));

    // R2 latency and hold; R3 late operand change ignored
    @(negedge clk);
    opnd_a = 32'h40000000; opnd_b = 32'h40000000; req = 1'b1;
    @(negedge clk);
    chk(done === 1'b0, 2, {31'd0, done}, 32'd0);
    opnd_a = 32'h41000000; opnd_b = 32'hC0000000;
    @(negedge clk);
    chk(done === 1'b0, 2, {31'd0, done}, 32'd0);
    @(negedge clk);
    chk(done === 1'b0, 2, {31'd0, done}, 32'd0);
    @(negedge clk);
    chk(done === 1'b1, 2, {31'd0, done}, 32'd1);
    chk(sum_word === 32'h40800000, 3, sum_word, 32'h40800000);
    repeat (3) @(negedge clk);
    chk(done === 1'b1 && sum_word === 32'h40800000, 2, sum_word, 32'h40800000);
    req = 1'b0;
    @(negedge clk);
    chk(done === 1'b0, 2, {31'd0, done}, 32'd0);
    // R2 idle without request: no done
    repeat (6) @(negedge clk);
    chk(done === 1'b0, 2, {31'd0, done}, 32'd0);

    summary();
  end
endmodule